// File: doc/BRIEF.md
# Two-Tile Reconfigurable Logic Fabric

This block is a small island-style logic fabric with two logic tiles. The first tile computes two fixed gate functions of three data inputs: a NAND of the first two inputs and a NOR of the last two. Each result enters a routing layer of held two-position steering switches. Each switch passes its input to one of two destinations, and a destination that no switch drives reads as 0. In tile-to-tile mode an inverter stage follows the first tile, and a second tile combines two routed first-tile results through a NAND and a NOR gate, each with one input inverted.

The six switch positions are stored in flops and stay put until a configuration write changes them. A write selects switches by row (word line) and column (bit line) and loads a one-bit position. The six routed outputs are combinational in the data inputs and in the stored positions. This lets a test sweep every input value against every switch setting.

Top module: `nem_fabric2`

## Requirements
- R1: After an active-low reset, all six switches are at position 0. In single-tile mode with that state, dout[0] is NAND(din[0],din[1]), dout[3] is NOR(din[1],din[2]), and the other outputs are 0.
- R2: The switch at row r and column c has index r*3+c. On the clock edge after cfg_we is high, every switch whose row bit in cfg_wl and column bit in cfg_bl are both 1 takes the value cfg_val. Several bits set at once write every crossing they select.
- R3: A cycle with cfg_we low, or with cfg_wl or cfg_bl all zero, leaves every switch position unchanged. The data inputs and tile2_en never change a switch position.
- R4: Single-tile mode (tile2_en=0) uses switches 0 to 2. Switch 0 at 0 sends the NAND result to dout[0]; at 1 it sends the result to the switch block. Switch 1 does the same for the NOR result and dout[3].
- R5: In single-tile mode, switch 2 at 0 sends the switch-block NAND path to dout[1] and the NOR path to dout[2]; at 1 it crosses them. dout[4] and dout[5] are 0, and switches 3 to 5 have no effect.
- R6: In tile-to-tile mode (tile2_en=1), dout[0] is AND(din[0],din[1]) while switch 0 is at 0 and is 0 otherwise. dout[5] is OR(din[1],din[2]) while switch 1 is at 0 and is 0 otherwise. Switch 2 has no effect.
- R7: In tile-to-tile mode, dout[1] is the NOR result when switch 3 is 1 and the NAND result otherwise. dout[4] is the NAND result when switch 4 is 1 and the NOR result otherwise.
- R8: In tile-to-tile mode with switch 5 at 0, dout[2] is NAND(NOT dout[1], dout[4]) and dout[3] is NOR(NOT dout[4], dout[1]). With switch 5 at 1, both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Asynchronous active-low reset of switch positions |
| tile2_en | input | 1 | 0 selects single-tile mode, 1 selects tile-to-tile mode |
| din | input | 3 | Data inputs; bit 0 is the first input |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wl | input | 2 | Row (word-line) select, one bit per row |
| cfg_bl | input | 3 | Column (bit-line) select, one bit per column |
| cfg_val | input | 1 | Position value to write |
| dout | output | 6 | Routed outputs; bit k is output k+1 |

## Verification
The bench builds the fabric with its default two rows and three columns, which gives six switches. The single-tile sweep covers all 64 combinations of three inputs and three active switches. The tile-to-tile sweep covers all 256 combinations of three inputs and five active switches. Each sweep also sets the switches of the other mode to changing values, which shows that those switches have no effect. Further scenarios write several crossings at once, try writes that select nothing, and toggle data and mode while the strobe is low.

// File: rtl/nem_fabric2.sv
module nem_fabric2 #(
  parameter int ROWS = 2,
  parameter int COLS = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tile2_en,
  input  logic [2:0]      din,
  input  logic            cfg_we,
  input  logic [ROWS-1:0] cfg_wl,
  input  logic [COLS-1:0] cfg_bl,
  input  logic            cfg_val,
  output logic [5:0]      dout
);
  localparam int NSW = ROWS * COLS;

  logic [NSW-1:0] sw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sw <= '0;
    else if (cfg_we)
      for (int r = 0; r < ROWS; r++)
        for (int c = 0; c < COLS; c++)
          if (cfg_wl[r] && cfg_bl[c]) sw[r*COLS+c] <= cfg_val;
  end

  logic g_nand, g_nor;
  assign g_nand = ~(din[0] & din[1]);
  assign g_nor  = ~(din[1] | din[2]);

  logic x_path, y_path;
  assign x_path = sw[0] & g_nand;
  assign y_path = sw[1] & g_nor;

  logic sel_a, sel_b, t2_nand, t2_nor;
  assign sel_a   = sw[3] ? g_nor  : g_nand;
  assign sel_b   = sw[4] ? g_nand : g_nor;
  assign t2_nand = ~(~sel_a & sel_b);
  assign t2_nor  = ~(~sel_b | sel_a);

  always_comb begin
    if (!tile2_en) begin
      dout[0] = sw[0] ? 1'b0 : g_nand;
      dout[3] = sw[1] ? 1'b0 : g_nor;
      dout[1] = sw[2] ? y_path : x_path;
      dout[2] = sw[2] ? x_path : y_path;
      dout[4] = 1'b0;
      dout[5] = 1'b0;
    end else begin
      dout[0] = sw[0] ? 1'b0 : ~g_nand;
      dout[5] = sw[1] ? 1'b0 : ~g_nor;
      dout[1] = sel_a;
      dout[4] = sel_b;
      dout[2] = sw[5] ? 1'b0 : t2_nand;
      dout[3] = sw[5] ? 1'b0 : t2_nor;
    end
  end

  a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_we || cfg_wl == '0 || cfg_bl == '0) |=> $stable(sw));

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      a_r2_cell_write: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_wl[r] && cfg_bl[c]) |=> sw[r*COLS+c] == $past(cfg_val));
    end
  end

  a_r5_single_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !tile2_en |-> (dout[4] == 1'b0 && dout[5] == 1'b0));

  a_r6_and_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (tile2_en && !sw[0]) |-> dout[0] == (din[0] & din[1]));

  a_r8_tile2_nand: assert property (@(posedge clk) disable iff (!rst_n)
    (tile2_en && !sw[5]) |-> dout[2] == ~(~dout[1] & dout[4]));

  a_r8_tile2_nor: assert property (@(posedge clk) disable iff (!rst_n)
    (tile2_en && !sw[5]) |-> dout[3] == ~(~dout[4] | dout[1]));
endmodule

// File: tb/nem_fabric2_tb_top.sv
module nem_fabric2_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tile2_en = 1'b0;
  logic [2:0] din = '0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_wl = '0;
  logic [2:0] cfg_bl = '0;
  logic       cfg_val = 1'b0;
  logic [5:0] dout;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  nem_fabric2 dut_i (
    .clk(clk), .rst_n(rst_n), .tile2_en(tile2_en), .din(din),
    .cfg_we(cfg_we), .cfg_wl(cfg_wl), .cfg_bl(cfg_bl), .cfg_val(cfg_val),
    .dout(dout)
  );

  function automatic logic [5:0] model(input logic m, input logic [5:0] s, input logic [2:0] d);
    logic [5:0] o;
    logic na, no, x, y, p, q;
    na = ~(d[0] & d[1]);
    no = ~(d[1] | d[2]);
    o = '0;
    if (!m) begin
      x = s[0] & na;
      y = s[1] & no;
      o[0] = s[0] ? 1'b0 : na;
      o[3] = s[1] ? 1'b0 : no;
      o[1] = s[2] ? y : x;
      o[2] = s[2] ? x : y;
    end else begin
      p = s[3] ? no : na;
      q = s[4] ? na : no;
      o[0] = s[0] ? 1'b0 : (d[0] & d[1]);
      o[5] = s[1] ? 1'b0 : (d[1] | d[2]);
      o[1] = p;
      o[4] = q;
      o[2] = s[5] ? 1'b0 : ~(~p & q);
      o[3] = s[5] ? 1'b0 : ~(~q | p);
    end
    return o;
  endfunction

  task automatic check(input string req, input logic [5:0] exp);
    checks++;
    if (dout !== exp) begin
      errors++;
      $display("FAIL %s mode=%0b din=%b dout=%b expected=%b", req, tile2_en, din, dout, exp);
    end
  endtask

  task automatic write_cell(input int idx, input logic v);
    @(negedge clk);
    cfg_wl = 2'b01 << (idx / 3);
    cfg_bl = 3'b001 << (idx % 3);
    cfg_val = v;
    cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    cfg_wl = '0;
    cfg_bl = '0;
  endtask

  task automatic load_all(input logic [5:0] s);
    for (int i = 0; i < 6; i++) write_cell(i, s[i]);
  endtask

  task automatic sweep_inputs(input string req, input logic [5:0] s);
    for (int d = 0; d < 8; d++) begin
      din = d[2:0];
      #1;
      check(req, model(tile2_en, s, din));
    end
  endtask

  task automatic t_reset;
    tile2_en = 1'b0;
    sweep_inputs("R1", 6'b000000);
  endtask

  task automatic t_single_sweep;
    logic [5:0] s;
    tile2_en = 1'b0;
    for (int k = 0; k < 8; k++) begin
      s = {k[2:0] ^ 3'b101, k[2:0]};
      load_all(s);
      sweep_inputs("R4_R5", s);
    end
  endtask

  task automatic t_tile2_sweep;
    logic [5:0] s;
    tile2_en = 1'b1;
    for (int k = 0; k < 32; k++) begin
      s = {k[4:2], k[0], k[1:0]};
      s[2] = ~k[0];
      load_all(s);
      sweep_inputs("R6_R7_R8", s);
    end
  endtask

  task automatic t_multi_write;
    load_all(6'b000000);
    @(negedge clk);
    cfg_wl = 2'b11;
    cfg_bl = 3'b101;
    cfg_val = 1'b1;
    cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    tile2_en = 1'b1;
    sweep_inputs("R2", 6'b101101);
    tile2_en = 1'b0;
    sweep_inputs("R2", 6'b101101);
  endtask

  task automatic t_no_effect;
    load_all(6'b010010);
    @(negedge clk);
    cfg_wl = 2'b11; cfg_bl = 3'b111; cfg_val = 1'b1; cfg_we = 1'b0;
    @(negedge clk);
    cfg_wl = 2'b00; cfg_bl = 3'b111; cfg_we = 1'b1;
    @(negedge clk);
    cfg_wl = 2'b11; cfg_bl = 3'b000;
    @(negedge clk);
    cfg_we = 1'b0; cfg_wl = '0; cfg_bl = '0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      din = i[2:0];
      tile2_en = i[0];
    end
    tile2_en = 1'b1;
    sweep_inputs("R3", 6'b010010);
    tile2_en = 1'b0;
    sweep_inputs("R3", 6'b010010);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single_sweep();
    t_tile2_sweep();
    t_multi_write();
    t_no_effect();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule